// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block holds the programmable state of an eight-line interrupt controller and decodes every access made to its byte-wide, two-address port. It has no request latch and no priority search of its own. Beside it, a request latch supplies the current request vector, and a resolver supplies two results: the winning pending line and the highest-priority line that is in service. The resolver works from this block's in-service, mask and rotation-offset outputs.

Address 0 takes three kinds of write: the start of initialization, control words (poll, register-read select, special mask) and coded end-of-interrupt and rotation commands. Address 1 takes the remaining initialization words, then mask writes once the controller is in normal operation. An acknowledge strobe, or a read that follows a poll request, accepts the winning line. This updates the in-service state and drives the vector number. The acknowledged line is also reported so the request latch can clear an edge request.

Top module: `intc_cmd_unit`

## Requirements
- R1: After reset the in-service register, mask register, rotation offset, all mode flags and the vector base are zero, and the controller is in normal operation with the request register selected for address-0 reads.
- R2: An address-0 write with data bit 4 set clears the in-service register, mask, offset, vector base, poll flag, read select, special mask and all mode flags. The next address-1 write loads the vector base from data[7:3] and does not change the mask.
- R3: After the base word, the sequence runs as follows. With single mode (bit 1 of the first word) set, it goes to the mode word if a mode word was requested (bit 0 of the first word), and otherwise to normal operation. With single mode clear, it goes to a cascade word, then to the mode word or to normal operation as above.
- R4: In the mode word, data bit 4 sets the nested-mode flag and data bit 1 sets automatic end-of-interrupt.
- R5: In normal operation an address-1 write loads the mask register, and an address-1 read returns it.
- R6: An address-0 write with bit 3 set and bit 4 clear is a control word. Bit 2 sets the poll flag. When bit 1 is set, bit 0 selects the in-service register (1) or the request register (0) for address-0 reads. When bit 6 is set, bit 5 becomes the special-mask flag.
- R7: Command code data[7:5]=1 clears the in-service bit of the line the resolver reports as highest in service. Code 5 does the same and also sets the offset to that line plus 1, modulo 8. When no line is in service, both codes leave all state unchanged.
- R8: Code 3 clears the in-service bit named by data[2:0]. Code 7 does the same and also sets the offset to that line plus 1, modulo 8.
- R9: Code 6 sets the offset to data[2:0] plus 1, modulo 8. Code 2 changes nothing.
- R10: An acknowledge with a winning line and automatic end-of-interrupt off sets that line's in-service bit. The vector output is then {base, line}.
- R11: With automatic end-of-interrupt on, an acknowledge sets no in-service bit. If the rotate flag is set, the offset becomes the line plus 1. Codes 0 and 4 write data bit 7 into the rotate flag.
- R12: An acknowledge with no winning line gives vector {base, 7} and changes no state.
- R13: A read while the poll flag is set returns 0x80 OR the winning line and acknowledges that line as in R10 and R11. With no winner it returns 0. Any read clears the poll flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 1 | Port address (0 or 1) |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data |
| irr_i | input | 8 | Request vector from the request latch |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| win_valid_i | input | 1 | Resolver has a winning pending line |
| win_line_i | input | 3 | Winning pending line |
| isr_top_valid_i | input | 1 | Some line is in service |
| isr_top_line_i | input | 3 | Highest-priority in-service line |
| vector_o | output | 8 | Vector number for the acknowledge |
| take_o | output | 1 | A line was accepted this cycle |
| take_line_o | output | 3 | Line accepted |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |
| offset_o | output | 3 | Rotation offset (line of top priority) |
| spec_mask_o | output | 1 | Special-mask flag |
| nested_o | output | 1 | Nested-mode flag |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt flag |

## Verification
The bench walks all four initialization paths and confirms that the word after each sequence lands in the mask. A decoder that took a wrong branch would instead load the mask with a cascade or mode word, or store a mode word as a mask. It issues non-specific end-of-interrupt commands with the offset rotated and with nothing in service. A wrong implementation would clear the lowest-numbered line instead of the top-priority one, or would move the offset when nothing was in service. Poll reads are checked with and without a winner and immediately followed by a plain read, which shows a stuck poll flag or a missing acknowledge. Acknowledges in automatic end-of-interrupt mode, with rotation on and off, show whether in-service bits leak in and whether the offset moves only when it should.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NLINES = 8;
  localparam int LW     = $clog2(NLINES);
  localparam int DW     = 8;
  localparam int BW     = DW - LW;

  typedef enum logic [1:0] {
    IS_RUN,
    IS_BASE,
    IS_CASC,
    IS_MODE
  } init_st_e;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_INIT,
    OP_CTRL,
    OP_MASK,
    OP_BASE,
    OP_CASC,
    OP_MODE,
    OP_ROTSET,
    OP_EOI_TOP,
    OP_EOI_TOP_ROT,
    OP_EOI_LN,
    OP_EOI_LN_ROT,
    OP_PRIO
  } op_e;
endpackage

// File: rtl/intc_wr_decode.sv
module intc_wr_decode
  import intc_pkg::*;
(
  input  logic          wr_en,
  input  logic          addr,
  input  logic [BW-1:0] d_hi,
  input  init_st_e      st,
  output op_e           op
);
  // d_hi holds data[7:3]: [1] = bit 4, [0] = bit 3, [4:2] = command code
  always_comb begin
    op = OP_NONE;
    if (wr_en) begin
      if (!addr) begin
        if (d_hi[1])      op = OP_INIT;
        else if (d_hi[0]) op = OP_CTRL;
        else begin
          case (d_hi[BW-1:BW-3])
            3'd0, 3'd4: op = OP_ROTSET;
            3'd1:       op = OP_EOI_TOP;
            3'd5:       op = OP_EOI_TOP_ROT;
            3'd3:       op = OP_EOI_LN;
            3'd7:       op = OP_EOI_LN_ROT;
            3'd6:       op = OP_PRIO;
            default:    op = OP_NONE;
          endcase
        end
      end else begin
        case (st)
          IS_RUN:  op = OP_MASK;
          IS_BASE: op = OP_BASE;
          IS_CASC: op = OP_CASC;
          default: op = OP_MODE;
        endcase
      end
    end
  end
endmodule

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [BW-1:0] d_hi,
  input  logic [1:0]    d_lo,
  output init_st_e      st_q,
  output logic [BW-1:0] base_q,
  output logic          nested_q,
  output logic          aeoi_q,
  output logic          rot_q
);
  init_st_e      st_d;
  logic [BW-1:0] base_d;
  logic          need4_q, need4_d, single_q, single_d;
  logic          nested_d, aeoi_d, rot_d;
  logic          en;

  assign en = (op == OP_INIT) || (op == OP_BASE) || (op == OP_CASC) ||
              (op == OP_MODE) || (op == OP_ROTSET);

  always_comb begin
    st_d     = st_q;
    base_d   = base_q;
    need4_d  = need4_q;
    single_d = single_q;
    nested_d = nested_q;
    aeoi_d   = aeoi_q;
    rot_d    = rot_q;
    case (op)
      OP_INIT: begin
        st_d     = IS_BASE;
        need4_d  = d_lo[0];
        single_d = d_lo[1];
        base_d   = '0;
        nested_d = 1'b0;
        aeoi_d   = 1'b0;
        rot_d    = 1'b0;
      end
      OP_BASE: begin
        base_d = d_hi;
        if (single_q) st_d = need4_q ? IS_MODE : IS_RUN;
        else          st_d = IS_CASC;
      end
      OP_CASC: st_d = need4_q ? IS_MODE : IS_RUN;
      OP_MODE: begin
        nested_d = d_hi[1];
        aeoi_d   = d_lo[1];
        st_d     = IS_RUN;
      end
      OP_ROTSET: rot_d = d_hi[BW-1];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= IS_RUN;
      base_q   <= '0;
      need4_q  <= 1'b0;
      single_q <= 1'b0;
      nested_q <= 1'b0;
      aeoi_q   <= 1'b0;
      rot_q    <= 1'b0;
    end else if (en) begin
      st_q     <= st_d;
      base_q   <= base_d;
      need4_q  <= need4_d;
      single_q <= single_d;
      nested_q <= nested_d;
      aeoi_q   <= aeoi_d;
      rot_q    <= rot_d;
    end
  end
endmodule

// File: rtl/intc_svc_state.sv
module intc_svc_state
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [LW-1:0]     wline,
  input  logic              top_valid,
  input  logic [LW-1:0]     top_line,
  input  logic              take,
  input  logic [LW-1:0]     take_line,
  input  logic              aeoi,
  input  logic              rot_aeoi,
  output logic [NLINES-1:0] isr_q,
  output logic [LW-1:0]     off_q
);
  logic [NLINES-1:0] isr_d;
  logic [LW-1:0]     off_d;
  logic              en;

  assign en = (op != OP_NONE) || take;

  always_comb begin
    isr_d = isr_q;
    off_d = off_q;
    case (op)
      OP_INIT: begin
        isr_d = '0;
        off_d = '0;
      end
      OP_EOI_TOP, OP_EOI_TOP_ROT: begin
        if (top_valid) begin
          isr_d[top_line] = 1'b0;
          if (op == OP_EOI_TOP_ROT) off_d = top_line + LW'(1);
        end
      end
      OP_EOI_LN, OP_EOI_LN_ROT: begin
        isr_d[wline] = 1'b0;
        if (op == OP_EOI_LN_ROT) off_d = wline + LW'(1);
      end
      OP_PRIO: off_d = wline + LW'(1);
      default: begin
        if (take) begin
          if (aeoi) begin
            if (rot_aeoi) off_d = take_line + LW'(1);
          end else begin
            isr_d[take_line] = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      off_q <= '0;
    end else if (en) begin
      isr_q <= isr_d;
      off_q <= off_d;
    end
  end
endmodule

// File: rtl/intc_cmd_unit.sv
module intc_cmd_unit
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NLINES-1:0] irr_i,
  input  logic              ack_i,
  input  logic              win_valid_i,
  input  logic [LW-1:0]     win_line_i,
  input  logic              isr_top_valid_i,
  input  logic [LW-1:0]     isr_top_line_i,
  output logic [DW-1:0]     vector_o,
  output logic              take_o,
  output logic [LW-1:0]     take_line_o,
  output logic [NLINES-1:0] isr_o,
  output logic [NLINES-1:0] imr_o,
  output logic [LW-1:0]     offset_o,
  output logic              spec_mask_o,
  output logic              nested_o,
  output logic              auto_eoi_o
);
  op_e           op;
  init_st_e      init_q;
  logic [BW-1:0] base_q;
  logic          rot_q;

  logic [NLINES-1:0] imr_q, imr_d;
  logic              poll_q, poll_d;
  logic              rsel_q, rsel_d;
  logic              sm_q, sm_d;
  logic              ctl_en;
  logic              take;

  intc_wr_decode u_dec (
    .wr_en (wr_i),
    .addr  (addr_i),
    .d_hi  (wdata_i[DW-1:LW]),
    .st    (init_q),
    .op    (op)
  );

  intc_init_seq u_init (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .d_hi     (wdata_i[DW-1:LW]),
    .d_lo     (wdata_i[1:0]),
    .st_q     (init_q),
    .base_q   (base_q),
    .nested_q (nested_o),
    .aeoi_q   (auto_eoi_o),
    .rot_q    (rot_q)
  );

  // a line is accepted by an acknowledge or a poll read, never alongside a write
  assign take = (ack_i || (rd_i && poll_q)) && win_valid_i && (op == OP_NONE);

  intc_svc_state u_svc (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .wline     (wdata_i[LW-1:0]),
    .top_valid (isr_top_valid_i),
    .top_line  (isr_top_line_i),
    .take      (take),
    .take_line (win_line_i),
    .aeoi      (auto_eoi_o),
    .rot_aeoi  (rot_q),
    .isr_q     (isr_o),
    .off_q     (offset_o)
  );

  always_comb begin
    imr_d  = imr_q;
    poll_d = poll_q;
    rsel_d = rsel_q;
    sm_d   = sm_q;
    if (op == OP_INIT) begin
      imr_d  = '0;
      poll_d = 1'b0;
      rsel_d = 1'b0;
      sm_d   = 1'b0;
    end else if (op == OP_MASK) begin
      imr_d = wdata_i;
    end else if (op == OP_CTRL) begin
      if (wdata_i[2]) poll_d = 1'b1;
      if (wdata_i[1]) rsel_d = wdata_i[0];
      if (wdata_i[6]) sm_d   = wdata_i[5];
    end else if (rd_i) begin
      poll_d = 1'b0;
    end
  end

  assign ctl_en = (op == OP_INIT) || (op == OP_MASK) || (op == OP_CTRL) || rd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q  <= '0;
      poll_q <= 1'b0;
      rsel_q <= 1'b0;
      sm_q   <= 1'b0;
    end else if (ctl_en) begin
      imr_q  <= imr_d;
      poll_q <= poll_d;
      rsel_q <= rsel_d;
      sm_q   <= sm_d;
    end
  end

  always_comb begin
    if (poll_q) begin
      rdata_o = win_valid_i ? {1'b1, {(DW-1-LW){1'b0}}, win_line_i} : '0;
    end else if (!addr_i) begin
      rdata_o = rsel_q ? isr_o : irr_i;
    end else begin
      rdata_o = imr_q;
    end
  end

  assign vector_o    = {base_q, win_valid_i ? win_line_i : LW'(NLINES-1)};
  assign take_o      = take;
  assign take_line_o = win_line_i;
  assign imr_o       = imr_q;
  assign spec_mask_o = sm_q;
endmodule

// File: rtl/intc_cmd_unit_chk.sv
module intc_cmd_unit_chk
  import intc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              addr_i,
  input logic              wr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              rd_i,
  input logic              ack_i,
  input logic              win_valid_i,
  input logic [LW-1:0]     win_line_i,
  input logic              isr_top_valid_i,
  input logic [LW-1:0]     isr_top_line_i,
  input logic [NLINES-1:0] isr_o,
  input logic [NLINES-1:0] imr_o,
  input logic [LW-1:0]     offset_o,
  input logic              auto_eoi_o,
  input logic              run_mode,
  input logic              poll_q
);
  assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i && wdata_i[4]) |=> (isr_o == '0 && imr_o == '0 && offset_o == '0));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i && run_mode) |=> (imr_o == $past(wdata_i)));

  assert_eoi_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i && wdata_i[7:3] == 5'b00100 && isr_top_valid_i)
      |=> !isr_o[$past(isr_top_line_i)]);

  assert_eoi_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i && wdata_i[7:3] == 5'b01100) |=> !isr_o[$past(wdata_i[2:0])]);

  assert_set_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i && wdata_i[7:3] == 5'b11000)
      |=> (offset_o == $past(wdata_i[2:0]) + 3'd1));

  assert_ack_sets_isr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !wr_i && win_valid_i && !auto_eoi_o) |=> isr_o[$past(win_line_i)]);

  assert_spurious_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !wr_i && !win_valid_i) |=> ($stable(isr_o) && $stable(offset_o)));

  assert_poll_once_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && poll_q) |=> !poll_q);
endmodule

bind intc_cmd_unit intc_cmd_unit_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .addr_i          (addr_i),
  .wr_i            (wr_i),
  .wdata_i         (wdata_i),
  .rd_i            (rd_i),
  .ack_i           (ack_i),
  .win_valid_i     (win_valid_i),
  .win_line_i      (win_line_i),
  .isr_top_valid_i (isr_top_valid_i),
  .isr_top_line_i  (isr_top_line_i),
  .isr_o           (isr_o),
  .imr_o           (imr_o),
  .offset_o        (offset_o),
  .auto_eoi_o      (auto_eoi_o),
  .run_mode        (init_q == intc_pkg::IS_RUN),
  .poll_q          (poll_q)
);

// File: tb/intc_cmd_unit_bench.sv
module intc_cmd_unit_bench;
  localparam int CLK_P = 10;
  localparam int WD_CYC = 20000;
  localparam logic [7:0] IRR_PAT = 8'hA5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vector, isr, imr;
  logic       win_v = 1'b0;
  logic [2:0] win_l = '0;
  logic       top_v;
  logic [2:0] top_l, off, take_line;
  logic       take, smask, nested, aeoi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  intc_cmd_unit u_intc_cmd_unit (
    .clk (clk), .rst_n (rst_n), .addr_i (addr), .wr_i (wr), .wdata_i (wdata),
    .rd_i (rd), .rdata_o (rdata), .irr_i (IRR_PAT), .ack_i (ack),
    .win_valid_i (win_v), .win_line_i (win_l),
    .isr_top_valid_i (top_v), .isr_top_line_i (top_l),
    .vector_o (vector), .take_o (take), .take_line_o (take_line),
    .isr_o (isr), .imr_o (imr), .offset_o (off), .spec_mask_o (smask),
    .nested_o (nested), .auto_eoi_o (aeoi)
  );

  // resolver model: first in-service line counting up from the offset
  always_comb begin
    top_v = 1'b0;
    top_l = '0;
    for (int k = 7; k >= 0; k--) begin
      if (isr[3'(int'(off) + k)]) begin
        top_v = 1'b1;
        top_l = 3'(int'(off) + k);
      end
    end
  end

  // [31:30] kind (0 write, 1 read, 2 ack) [29] addr [28:21] data
  // [20:13] expected [12] winner valid [11:9] winner line
  function automatic logic [31:0] ent(logic [1:0] k, logic a, logic [7:0] d,
                                      logic [7:0] e, logic v, logic [2:0] l);
    return {k, a, d, e, v, l, 9'd0};
  endfunction

  localparam int NT = 23;
  localparam logic [31:0] TBL [NT] = '{
    ent(2'd0, 1'b0, 8'h13, 8'h00, 1'b0, 3'd0),  // R2 start, single + mode word
    ent(2'd0, 1'b1, 8'h40, 8'h00, 1'b0, 3'd0),  // R2 base 0x40
    ent(2'd0, 1'b1, 8'h00, 8'h00, 1'b0, 3'd0),  // R3 mode word
    ent(2'd0, 1'b1, 8'hF0, 8'h00, 1'b0, 3'd0),  // R5 mask
    ent(2'd1, 1'b1, 8'h00, 8'hF0, 1'b0, 3'd0),  // R5 mask readback
    ent(2'd1, 1'b0, 8'h00, 8'hA5, 1'b0, 3'd0),  // R6 request selected
    ent(2'd2, 1'b0, 8'h00, 8'h43, 1'b1, 3'd3),  // R10 vector base+3
    ent(2'd0, 1'b0, 8'h0B, 8'h00, 1'b0, 3'd0),  // R6 select in-service
    ent(2'd1, 1'b0, 8'h00, 8'h08, 1'b0, 3'd0),  // R10 isr bit 3
    ent(2'd2, 1'b0, 8'h00, 8'h41, 1'b1, 3'd1),  // R10 vector base+1
    ent(2'd1, 1'b0, 8'h00, 8'h0A, 1'b0, 3'd0),  // R10 isr 3,1
    ent(2'd0, 1'b0, 8'h20, 8'h00, 1'b0, 3'd0),  // R7 non-specific EOI
    ent(2'd1, 1'b0, 8'h00, 8'h08, 1'b0, 3'd0),  // R7 line 1 cleared
    ent(2'd0, 1'b0, 8'h63, 8'h00, 1'b0, 3'd0),  // R8 specific EOI line 3
    ent(2'd1, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0),  // R8 empty
    ent(2'd0, 1'b0, 8'h0A, 8'h00, 1'b0, 3'd0),  // R6 select request
    ent(2'd1, 1'b0, 8'h00, 8'hA5, 1'b0, 3'd0),  // R6 request read
    ent(2'd2, 1'b0, 8'h00, 8'h47, 1'b0, 3'd0),  // R12 spurious vector
    ent(2'd0, 1'b0, 8'h0C, 8'h00, 1'b0, 3'd0),  // R13 poll request
    ent(2'd1, 1'b0, 8'h00, 8'h85, 1'b1, 3'd5),  // R13 poll read line 5
    ent(2'd1, 1'b0, 8'h00, 8'hA5, 1'b1, 3'd5),  // R13 poll flag cleared
    ent(2'd0, 1'b0, 8'h0B, 8'h00, 1'b0, 3'd0),  // R13 select in-service
    ent(2'd1, 1'b0, 8'h00, 8'h20, 1'b0, 3'd0)   // R13 poll acknowledged line 5
  };

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic do_wr(logic a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_rd(logic a, logic v, logic [2:0] l, logic [7:0] exp, string tag);
    @(negedge clk);
    addr = a; rd = 1'b1; win_v = v; win_l = l;
    #1 check(tag, rdata, exp);
    @(negedge clk);
    rd = 1'b0; win_v = 1'b0;
  endtask

  task automatic do_ack(logic v, logic [2:0] l, logic [7:0] exp, string tag);
    @(negedge clk);
    ack = 1'b1; win_v = v; win_l = l;
    #1 check(tag, vector, exp);
    @(negedge clk);
    ack = 1'b0; win_v = 1'b0;
  endtask

  initial begin
    logic [7:0] isr_keep;
    repeat (3) @(negedge clk);
    #1;
    check("R1 isr after reset", isr, 8'h00);
    check("R1 mask after reset", imr, 8'h00);
    check("R1 offset after reset", {5'd0, off}, 8'h00);
    check("R1 flags after reset", {5'd0, nested, aeoi, smask}, 8'h00);
    rst_n = 1'b1;
    do_rd(1'b0, 1'b0, 3'd0, IRR_PAT, "R1 address 0 reads request");
    do_ack(1'b0, 3'd0, 8'h07, "R1 base zero spurious vector");

    for (int i = 0; i < NT; i++) begin
      case (TBL[i][31:30])
        2'd0: do_wr(TBL[i][29], TBL[i][28:21]);
        2'd1: do_rd(TBL[i][29], TBL[i][12], TBL[i][11:9], TBL[i][20:13],
                    $sformatf("table step %0d read", i));
        default: do_ack(TBL[i][12], TBL[i][11:9], TBL[i][20:13],
                        $sformatf("table step %0d vector", i));
      endcase
    end

    // R3 cascade with mode word; R4 auto EOI bit
    do_wr(1'b0, 8'h11); do_wr(1'b1, 8'h08); do_wr(1'b1, 8'h04); do_wr(1'b1, 8'h02);
    check("R4 auto EOI set", {7'd0, aeoi}, 8'h01);
    check("R4 nested clear", {7'd0, nested}, 8'h00);
    do_wr(1'b1, 8'h3C);
    check("R3 cascade+mode then mask", imr, 8'h3C);
    // R3 cascade without mode word
    do_wr(1'b0, 8'h10); do_wr(1'b1, 8'h10); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h55);
    check("R3 cascade only then mask", imr, 8'h55);
    // R3 single without mode word
    do_wr(1'b0, 8'h12); do_wr(1'b1, 8'h18); do_wr(1'b1, 8'h66);
    check("R3 single only then mask", imr, 8'h66);
    // R4 nested bit
    do_wr(1'b0, 8'h13); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h10);
    check("R4 nested set", {7'd0, nested}, 8'h01);

    // R11 auto EOI with and without rotation
    do_wr(1'b0, 8'h13); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h02);
    do_wr(1'b0, 8'h80);
    do_ack(1'b1, 3'd6, 8'h06, "R11 vector line 6");
    check("R11 no isr in auto EOI", isr, 8'h00);
    check("R11 rotate offset line+1", {5'd0, off}, 8'h07);
    do_wr(1'b0, 8'h00);
    do_ack(1'b1, 3'd2, 8'h02, "R11 vector line 2");
    check("R11 rotate off keeps offset", {5'd0, off}, 8'h07);

    // R7 rotating non-specific EOI and empty EOI
    do_wr(1'b0, 8'h13); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h00);
    do_ack(1'b1, 3'd4, 8'h04, "R10 vector line 4");
    do_ack(1'b1, 3'd6, 8'h06, "R10 vector line 6");
    check("R10 isr 4,6", isr, 8'h50);
    do_wr(1'b0, 8'hA0);
    check("R7 code 5 clears top line", isr, 8'h40);
    check("R7 code 5 offset", {5'd0, off}, 8'h05);
    do_wr(1'b0, 8'h20);
    check("R7 code 1 after rotation", isr, 8'h00);
    do_wr(1'b0, 8'hA0);
    check("R7 empty EOI keeps offset", {5'd0, off}, 8'h05);
    check("R7 empty EOI keeps isr", isr, 8'h00);

    // R8 code 7
    do_ack(1'b1, 3'd2, 8'h02, "R10 vector line 2");
    do_wr(1'b0, 8'hE2);
    check("R8 code 7 clears line", isr, 8'h00);
    check("R8 code 7 offset", {5'd0, off}, 8'h03);

    // R9 code 6 wrap and code 2
    do_wr(1'b0, 8'hC7);
    check("R9 offset wraps", {5'd0, off}, 8'h00);
    do_wr(1'b0, 8'hC2);
    check("R9 offset 3", {5'd0, off}, 8'h03);
    do_ack(1'b1, 3'd1, 8'h01, "R10 vector line 1");
    isr_keep = isr;
    do_wr(1'b0, 8'h45);
    check("R9 code 2 offset kept", {5'd0, off}, 8'h03);
    check("R9 code 2 isr kept", isr, isr_keep);

    // R2 init clears, base word leaves mask
    do_wr(1'b1, 8'hFF);
    do_wr(1'b0, 8'h13);
    check("R2 isr cleared", isr, 8'h00);
    check("R2 mask cleared", imr, 8'h00);
    do_wr(1'b1, 8'h88);
    check("R2 base write leaves mask", imr, 8'h00);
    do_ack(1'b0, 3'd0, 8'h8F, "R2 new base in spurious vector");
    do_wr(1'b1, 8'h00);

    // R13 poll with nothing pending
    do_wr(1'b0, 8'h0C);
    do_rd(1'b1, 1'b0, 3'd0, 8'h00, "R13 poll read none");
    check("R13 poll none isr", isr, 8'h00);
    do_rd(1'b1, 1'b0, 3'd0, 8'h00, "R13 mask read after poll");

    // R6 special mask
    do_wr(1'b0, 8'h68);
    check("R6 special mask set", {7'd0, smask}, 8'h01);
    do_wr(1'b0, 8'h28);
    check("R6 special mask kept without enable", {7'd0, smask}, 8'h01);
    do_wr(1'b0, 8'h48);
    check("R6 special mask cleared", {7'd0, smask}, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (every requirement) got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule